// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that counts ticks of a slow reference strobe and reacts in two steps. When the count reaches an early threshold it raises a level interrupt, so software gets a warning while there is still time to recover. When the count reaches a later threshold it emits a fixed-length reset request toward the system reset controller. Software keeps the system alive by writing the restart register. This zeroes the counter and clears the warning.

Software reaches the block over a simple 32-bit register bus. Writes are single-cycle strobes and reads are combinational from the word address. One status bit lives in the power-on reset domain. It survives the reset that the watchdog itself causes, so boot code can tell a watchdog reset apart from a cold start. Both thresholds are counted in reference ticks and are clamped to a parameterised maximum. The counter stops at the reset threshold and does not wrap.

Top module: `wdt_bark_bite`

## Requirements
- R1: After reset, bark_irq and bite_req are low, the enable and status words read 0, and both threshold words read MAX_TICKS (0x10000000 by default).
- R2: The enable word (offset 0x08, bit 0) starts counting on a write of 1 and stops it on a write of 0, and a read returns the current state. While disabled, the counter holds its value and neither output can rise.
- R3: Writing a value with bit 0 set to the restart word (offset 0x04) clears the counter and the bark interrupt in the same clock edge. Writing a value with bit 0 clear has no effect.
- R4: bark_irq rises on the clock edge after the counter first equals or exceeds the bark threshold while enabled. It then stays high until a restart or a disabling write clears it.
- R5: When the counter reaches the bite threshold while enabled, bite_req goes high on the next edge and stays high for exactly BITE_LEN clock cycles.
- R6: The counter stops advancing at the bite threshold. No second bite_req pulse occurs until a restart, however many further ticks arrive.
- R7: When the bark and bite thresholds are equal, bark_irq and bite_req rise on the same clock edge.
- R8: The bark threshold sits at offset 0x10 and the bite threshold at offset 0x14. A write above MAX_TICKS is stored as MAX_TICKS, and the stored value reads back.
- R9: Status bit 0 (offset 0x0C) is set by a bite. It stays set through rst_n and is cleared only by por_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low system reset (also the reset a bite causes) |
| por_n | input | 1 | Active-low power-on reset; also clears the status bit |
| ref_tick | input | 1 | One-cycle strobe per reference-clock tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 5 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| bark_irq | output | 1 | Level early-warning interrupt |
| bite_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with BITE_LEN set to 3 and the default MAX_TICKS. The short pulse lets every cycle of a bite be sampled one by one. The full-size maximum keeps the clamp check on the real 0x10000000 boundary. The bench programs thresholds of only a few ticks, so it reaches the bark, the bite, saturation, equal thresholds and the split between the two reset domains within a few hundred cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int BUS_AW = 5;

  // word index = byte address [4:2]
  typedef enum logic [2:0] {
    IDX_RESTART = 3'd1,
    IDX_ENABLE  = 3'd2,
    IDX_STATUS  = 3'd3,
    IDX_BARK    = 3'd4,
    IDX_BITE    = 3'd5
  } wdt_idx_e;

  function automatic logic [31:0] clamp_time(input logic [31:0] req,
                                             input logic [31:0] maxv);
    return (req > maxv) ? maxv : req;
  endfunction

  function automatic logic reached(input logic [31:0] cnt,
                                   input logic [31:0] thr);
    return cnt >= thr;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned MAX_TICKS = 32'h1000_0000,
  parameter int CNT_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              status_i,
  output logic              en_o,
  output logic              en_clear_o,
  output logic              restart_o,
  output logic [CNT_W-1:0]  bark_thr_o,
  output logic [CNT_W-1:0]  bite_thr_o,
  output logic [31:0]       bus_rdata
);
  localparam int PAD = 32 - CNT_W;
  localparam logic [31:0] MAXV = 32'(MAX_TICKS);

  logic        aligned;
  logic [2:0]  widx;
  logic        wr_hit;
  logic [31:0] wr_clamped;
  logic        en_q;
  logic [CNT_W-1:0] bark_q, bite_q;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign widx       = bus_addr[4:2];
  assign wr_hit     = bus_sel && bus_wr && aligned;
  assign wr_clamped = clamp_time(bus_wdata, MAXV);

  assign restart_o  = wr_hit && (widx == IDX_RESTART) && bus_wdata[0];
  assign en_clear_o = wr_hit && (widx == IDX_ENABLE) && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bark_q <= MAXV[CNT_W-1:0];
      bite_q <= MAXV[CNT_W-1:0];
    end else if (wr_hit) begin
      case (widx)
        IDX_ENABLE: en_q   <= bus_wdata[0];
        IDX_BARK:   bark_q <= wr_clamped[CNT_W-1:0];
        IDX_BITE:   bite_q <= wr_clamped[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (aligned) begin
      case (widx)
        IDX_ENABLE: bus_rdata = {31'd0, en_q};
        IDX_STATUS: bus_rdata = {31'd0, status_i};
        IDX_BARK:   bus_rdata = {{PAD{1'b0}}, bark_q};
        IDX_BITE:   bus_rdata = {{PAD{1'b0}}, bite_q};
        default:    bus_rdata = 32'd0;
      endcase
    end
  end

  assign en_o       = en_q;
  assign bark_thr_o = bark_q;
  assign bite_thr_o = bite_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             en_clear,
  input  logic             restart,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] bark_thr,
  input  logic [CNT_W-1:0] bite_thr,
  output logic [CNT_W-1:0] count_o,
  output logic             bark_irq_o,
  output logic             bite_fire_o
);
  localparam int PAD = 32 - CNT_W;

  logic [CNT_W-1:0] count_q;
  logic             irq_q;
  logic             bitten_q;
  logic             at_bark, at_bite, advance;

  assign at_bark = reached({{PAD{1'b0}}, count_q}, {{PAD{1'b0}}, bark_thr});
  assign at_bite = reached({{PAD{1'b0}}, count_q}, {{PAD{1'b0}}, bite_thr});
  assign advance = en && ref_tick && !at_bite;
  assign bite_fire_o = en && at_bite && !bitten_q && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      irq_q    <= 1'b0;
      bitten_q <= 1'b0;
    end else begin
      if (restart) begin
        count_q  <= '0;
        bitten_q <= 1'b0;
      end else begin
        if (advance) count_q <= count_q + 1'b1;
        if (bite_fire_o) bitten_q <= 1'b1;
      end
      if (restart || en_clear || !en) irq_q <= 1'b0;
      else if (at_bark)                irq_q <= 1'b1;
    end
  end

  assign count_o    = count_q;
  assign bark_irq_o = irq_q;

endmodule

// File: rtl/wdt_bite.sv
module wdt_bite #(
  parameter int BITE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic fire,
  output logic bite_req_o,
  output logic status_o
);
  localparam int PW = $clog2(BITE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(BITE_LEN);

  logic [PW-1:0] left_q;
  logic          status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                left_q <= '0;
    else if (fire)             left_q <= LEN;
    else if (left_q != '0)     left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    status_q <= 1'b0;
    else if (fire) status_q <= 1'b1;
  end

  assign bite_req_o = (left_q != '0);
  assign status_o   = status_q;

endmodule

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite
  import wdt_pkg::*;
#(
  parameter int unsigned MAX_TICKS = 32'h1000_0000,
  parameter int BITE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bark_irq,
  output logic              bite_req
);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic             rst_all_n;
  logic             en_q, en_clear, restart_hit, bite_fire, wd_status;
  logic [CNT_W-1:0] bark_thr, bite_thr, count_q;

  assign rst_all_n = rst_n && por_n;

  wdt_regs #(.MAX_TICKS(MAX_TICKS), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_all_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(wd_status),
    .en_o(en_q), .en_clear_o(en_clear), .restart_o(restart_hit),
    .bark_thr_o(bark_thr), .bite_thr_o(bite_thr), .bus_rdata(bus_rdata)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_all_n), .en(en_q), .en_clear(en_clear),
    .restart(restart_hit), .ref_tick(ref_tick), .bark_thr(bark_thr),
    .bite_thr(bite_thr), .count_o(count_q), .bark_irq_o(bark_irq),
    .bite_fire_o(bite_fire)
  );

  wdt_bite #(.BITE_LEN(BITE_LEN)) u_bite (
    .clk(clk), .rst_n(rst_all_n), .por_n(por_n), .fire(bite_fire),
    .bite_req_o(bite_req), .status_o(wd_status)
  );

endmodule

// File: rtl/wdt_bark_bite_chk.sv
module wdt_bark_bite_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst_all_n,
  input logic             por_n,
  input logic             en_q,
  input logic             restart_hit,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] bite_thr,
  input logic             bite_fire,
  input logic             wd_status,
  input logic             bark_irq,
  input logic             bite_req
);

  // R2: a disabled counter holds its value
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_all_n)
    (!en_q && !restart_hit) |=> $stable(count_q));

  // R2: no output may rise while disabled
  p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_all_n)
    !en_q |=> !$rose(bark_irq) && !$rose(bite_req));

  // R3: restart zeroes the counter and drops the warning
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_all_n)
    restart_hit |=> (count_q == '0) && !bark_irq);

  // R5: a bite event starts the reset request
  p_bite_start_r5: assert property (@(posedge clk) disable iff (!rst_all_n)
    bite_fire |=> bite_req);

  // R6: no advance past the bite threshold
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_all_n)
    (count_q >= bite_thr && !restart_hit) |=> $stable(count_q));

  // R9: a reset request is always recorded in status
  p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(bite_req) |-> wd_status);

  // R9: status survives the system reset
  p_status_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_all_n && wd_status) |=> wd_status);

endmodule

bind wdt_bark_bite wdt_bark_bite_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_all_n(rst_all_n), .por_n(por_n), .en_q(en_q),
  .restart_hit(restart_hit), .count_q(count_q), .bite_thr(bite_thr),
  .bite_fire(bite_fire), .wd_status(wd_status), .bark_irq(bark_irq),
  .bite_req(bite_req)
);

// File: tb/wdt_bark_bite_bench.sv
module wdt_bark_bite_bench;
  localparam int BL = 3;
  localparam logic [31:0] MAXT = 32'h1000_0000;
  localparam logic [4:0] A_RST = 5'h04, A_EN = 5'h08, A_ST = 5'h0C,
                         A_BARK = 5'h10, A_BITE = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, ref_tick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bark_irq, bite_req;

  always #2 clk = ~clk;

  wdt_bark_bite #(.BITE_LEN(BL)) u_wdt_bark_bite (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bark_irq(bark_irq), .bite_req(bite_req)
  );

  typedef struct {
    string       req;
    logic [31:0] act;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;

  // driver side: push expected against observed
  task automatic expect_eq(input string req, input logic [31:0] act,
                           input logic [31:0] exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  // monitor side: pop and compare
  always @(posedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, it.act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 irq", {31'd0, bark_irq}, 0);
    expect_eq("R1 bite", {31'd0, bite_req}, 0);
    bus_read(A_EN, rd);   expect_eq("R1 enable", rd, 0);
    bus_read(A_ST, rd);   expect_eq("R1 status", rd, 0);
    bus_read(A_BARK, rd); expect_eq("R1 bark reset", rd, MAXT);
    bus_read(A_BITE, rd); expect_eq("R1 bite reset", rd, MAXT);

    // R8 programming and readback
    bus_write(A_BARK, 3); bus_write(A_BITE, 6);
    bus_read(A_BARK, rd); expect_eq("R8 bark rb", rd, 3);
    bus_read(A_BITE, rd); expect_eq("R8 bite rb", rd, 6);
    bus_write(A_EN, 1);
    bus_read(A_EN, rd);   expect_eq("R2 enable rb", rd, 1);

    // R4 bark timing
    ticks(2); @(negedge clk);
    expect_eq("R4 below bark", {31'd0, bark_irq}, 0);
    ticks(1); @(negedge clk);
    expect_eq("R4 bark raised", {31'd0, bark_irq}, 1);
    ticks(1); @(negedge clk);
    expect_eq("R4 bark held", {31'd0, bark_irq}, 1);

    // R3 restart clears
    bus_write(A_RST, 1);
    expect_eq("R3 restart clears irq", {31'd0, bark_irq}, 0);

    // R2 disabled: counter holds, outputs quiet
    bus_write(A_EN, 0);
    ticks(8); @(negedge clk);
    expect_eq("R2 irq off", {31'd0, bark_irq}, 0);
    expect_eq("R2 bite off", {31'd0, bite_req}, 0);
    bus_write(A_EN, 1); @(negedge clk);
    expect_eq("R2 count held at zero", {31'd0, bark_irq}, 0);
    ticks(3); @(negedge clk);
    expect_eq("R4 bark after reenable", {31'd0, bark_irq}, 1);

    // R5 bite pulse length
    ticks(2); @(negedge clk);
    expect_eq("R5 no bite before threshold", {31'd0, bite_req}, 0);
    ticks(1);
    for (int i = 0; i < BL; i++) begin
      @(negedge clk);
      expect_eq("R5 bite high", {31'd0, bite_req}, 1);
    end
    @(negedge clk);
    expect_eq("R5 bite ends", {31'd0, bite_req}, 0);
    bus_read(A_ST, rd); expect_eq("R9 status set", rd, 1);

    // R6 saturation: no second bite
    for (int i = 0; i < 8; i++) begin
      ticks(1); @(negedge clk);
      expect_eq("R6 no second bite", {31'd0, bite_req}, 0);
    end

    // R9 status vs the two resets
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_read(A_ST, rd); expect_eq("R9 status survives rst_n", rd, 1);
    bus_read(A_EN, rd); expect_eq("R1 enable after rst_n", rd, 0);
    expect_eq("R1 irq after rst_n", {31'd0, bark_irq}, 0);
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk); por_n = 1'b1;
    bus_read(A_ST, rd); expect_eq("R9 status cleared by por_n", rd, 0);

    // R7 equal thresholds
    bus_write(A_BARK, 2); bus_write(A_BITE, 2); bus_write(A_EN, 1);
    ticks(1); @(negedge clk);
    expect_eq("R7 early irq", {31'd0, bark_irq}, 0);
    ticks(1); @(negedge clk);
    expect_eq("R7 irq together", {31'd0, bark_irq}, 1);
    expect_eq("R7 bite together", {31'd0, bite_req}, 1);
    repeat (BL) @(negedge clk);

    // R3 restart with bit 0 clear is ignored
    bus_write(A_RST, 32'hFFFF_FFFE);
    expect_eq("R3 zero restart ignored", {31'd0, bark_irq}, 1);
    bus_write(A_RST, 1);
    expect_eq("R3 restart clears irq again", {31'd0, bark_irq}, 0);

    // R4 disable clears the warning
    bus_write(A_BITE, 50); bus_write(A_BARK, 1);
    ticks(1); @(negedge clk);
    expect_eq("R4 irq before disable", {31'd0, bark_irq}, 1);
    bus_write(A_EN, 0);
    expect_eq("R4 disable clears irq", {31'd0, bark_irq}, 0);
    bus_read(A_EN, rd); expect_eq("R2 enable reads 0", rd, 0);

    // R8 clamp
    bus_write(A_BITE, 32'hFFFF_FFFF);
    bus_read(A_BITE, rd); expect_eq("R8 bite clamp", rd, MAXT);
    bus_write(A_BARK, MAXT + 1);
    bus_read(A_BARK, rd); expect_eq("R8 bark clamp", rd, MAXT);
    bus_write(A_BARK, 32'h0123);
    bus_read(A_BARK, rd); expect_eq("R8 bark small", rd, 32'h0123);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule